// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt the processor takes next. It arbitrates a set of maskable sources, a separate set of macro-service requests and one non-maskable request. Each maskable source has a programmable priority level. Level 0 is the most urgent and the largest level number is the least urgent. Each source also has a fixed default rank: a lower source index ranks higher. Each request is captured on its rising edge, and the capture stays until that request is acknowledged.

A small in-service stack records the level of every maskable interrupt that has been accepted and has not yet finished. A new maskable request preempts only when the global enable is set and the request is more urgent than the top entry on the stack. A mode input decides one special case: whether a request at the least urgent level may nest inside a service routine of that same level.

Macro-service requests do not go through these checks. The non-maskable request outranks everything. Software sets the global enable through a pulse input, and every maskable acknowledge clears it again. Software signals the end of a service routine with a single-cycle pulse, which pops the stack. The pending requests are then arbitrated again against the level that is restored.

Top module: `prio_nest_intc`

## Requirements
- R1: A rising edge on a maskable request input sets that source's pending flag. The flag stays set until that source is acknowledged. A set mask bit keeps the source out of arbitration but leaves its pending flag set, so clearing the mask later lets the held request be acknowledged.
- R2: A maskable acknowledge happens only while the global enable is set. Every maskable acknowledge clears the global enable, and `ie_o` then reads 0. A pulse on `ie_set_i` sets the enable and a pulse on `ie_clr_i` clears it.
- R3: Among pending, unmasked maskable sources, the one with the smallest level number wins. On equal levels the lowest source index wins, whatever order the requests arrived in.
- R4: While the in-service stack is not empty, a maskable request is accepted only if its level number is strictly smaller than the level on top of the stack. Otherwise it is held pending.
- R5: While a level-0 entry is on top of the stack, no maskable request is acknowledged, including another level-0 request. This holds even with the global enable set.
- R6: With `lock_i` = 1, a request at the least urgent level (3 for 2-bit levels) is held while a level-3 entry is on top of the stack. With `lock_i` = 0, such a request is accepted in that situation.
- R7: A pending macro-service request is acknowledged regardless of the global enable, the stack contents and any pending maskable requests. Among macro-service requests the lowest index goes first. A macro-service acknowledge does not change the stack.
- R8: A pending non-maskable request is acknowledged before any macro-service or maskable request. It ignores the global enable and does not change the stack.
- R9: A pulse on `eos_i` pops the top stack entry. A pulse on an empty stack leaves the depth at 0. After a pop, the held requests are re-arbitrated against the restored top, and the winner is acknowledged if it now qualifies.
- R10: The stack holds `STK_DEPTH` entries (5 by default). While it is full, no maskable request is acknowledged.
- R11: After reset, `ack_o`, `ie_o` and `depth_o` are 0. `ack_o` is a single-cycle strobe, at most one acknowledge happens per clock, and a request rising just before clock edge k is acknowledged at edge k+1. `ack_kind_o` encodes maskable as 0, macro service as 1 and non-maskable as 2. `ack_idx_o` reads 0 for a non-maskable acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Maskable request lines, captured on their rising edge |
| irq_lvl_i | input | N_SRC*LVL_W | Level of each source; source i uses bits [i*LVL_W +: LVL_W] |
| irq_mask_i | input | N_SRC | Per-source mask, 1 = blocked |
| ms_req_i | input | N_SRC | Macro-service request lines, captured on their rising edge |
| nmi_i | input | 1 | Non-maskable request, captured on its rising edge |
| ie_set_i | input | 1 | Pulse that sets the global enable |
| ie_clr_i | input | 1 | Pulse that clears the global enable |
| lock_i | input | 1 | 1 = no nesting of least-urgent-level requests inside each other |
| eos_i | input | 1 | End-of-service pulse that pops the stack |
| ack_o | output | 1 | Acknowledge strobe |
| ack_kind_o | output | 2 | 0 maskable, 1 macro service, 2 non-maskable |
| ack_idx_o | output | clog2(N_SRC) | Index of the acknowledged source |
| ie_o | output | 1 | Current global enable |
| depth_o | output | clog2(STK_DEPTH+1) | Number of stack entries |
| cur_lvl_o | output | LVL_W | Level on top of the stack, valid when depth_o is not 0 |

## Verification
The acceptance rule is swept over every pairing of in-service level and new-request level, under both settings of the mode input. This separates a strict outrank, an equal level, the level-0 block and the least-urgent-level special case. Each pairing then ends the outer service, which shows whether a held request is taken against the empty stack. Four arithmetic level patterns are raised all at once and drained one at a time, one of them with every level equal. These show whether arbitration sorts by level first and by index second. Further mixed patterns set the non-maskable request, macro-service requests and maskable requests against each other, a masked source, a stack filled to capacity and a pop on an empty stack, so that each class's ordering and its effect on the stack can be seen.

// File: rtl/pni_pkg.sv
package pni_pkg;
  typedef enum logic [1:0] {
    ACK_MASK  = 2'd0,
    ACK_MACRO = 2'd1,
    ACK_NMI   = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/pni_pend.sv
// Rising-edge capture with per-bit pending flags, cleared on acknowledge.
module pni_pend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] req_q, pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | (req_i & ~req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R1
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0);
endmodule

// File: rtl/pni_pick.sv
// Selects the most urgent request: smallest level, then lowest index.
module pni_pick #(
  parameter int N     = 8,
  parameter int LW    = 2,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*LW-1:0] lvl_i,
  output logic            vld_o,
  output logic [IW-1:0]   idx_o,
  output logic [LW-1:0]   lvl_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    lvl_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (!vld_o || (lvl_i[i*LW +: LW] <= lvl_o))) begin
        vld_o = 1'b1;
        idx_o = IW'(i);
        lvl_o = lvl_i[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/pni_stack.sv
// In-service level stack.
module pni_stack #(
  parameter int DEPTH = 5,
  parameter int LW    = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] top_o,
  output logic [CW-1:0] cnt_o
);
  logic [LW-1:0] ent_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_idx = empty_o ? '0 : CW'(cnt_q - 1'b1);
  assign top_o   = ent_q[top_idx];
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !full_o)
      cnt_d = CW'(cnt_q + 1'b1);
    else if (pop_i && !empty_o)
      cnt_d = CW'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o) ent_q[cnt_q] <= lvl_i;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc
  import pni_pkg::*;
#(
  parameter int  N_SRC     = 8,
  parameter int  LVL_W     = 2,
  parameter int  STK_DEPTH = 5,
  localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CNT_W     = $clog2(STK_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       irq_i,
  input  logic [N_SRC*LVL_W-1:0] irq_lvl_i,
  input  logic [N_SRC-1:0]       irq_mask_i,
  input  logic [N_SRC-1:0]       ms_req_i,
  input  logic                   nmi_i,
  input  logic                   ie_set_i,
  input  logic                   ie_clr_i,
  input  logic                   lock_i,
  input  logic                   eos_i,
  output logic                   ack_o,
  output logic [1:0]             ack_kind_o,
  output logic [IDX_W-1:0]       ack_idx_o,
  output logic                   ie_o,
  output logic [CNT_W-1:0]       depth_o,
  output logic [LVL_W-1:0]       cur_lvl_o
);
  localparam logic [LVL_W-1:0] LVL_LAST = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [N_SRC-1:0] pend_irq, pend_ms, clr_irq, clr_ms;
  logic             pend_nmi, clr_nmi;

  pni_pend #(.W(N_SRC)) u_pend_irq (
    .clk(clk), .rst_n(rst_ni), .req_i(irq_i), .clr_i(clr_irq), .pend_o(pend_irq));
  pni_pend #(.W(N_SRC)) u_pend_ms (
    .clk(clk), .rst_n(rst_ni), .req_i(ms_req_i), .clr_i(clr_ms), .pend_o(pend_ms));
  pni_pend #(.W(1)) u_pend_nmi (
    .clk(clk), .rst_n(rst_ni), .req_i(nmi_i), .clr_i(clr_nmi), .pend_o(pend_nmi));

  logic             win_vld, ms_vld;
  logic [IDX_W-1:0] win_idx, ms_idx;
  logic [LVL_W-1:0] win_lvl, ms_lvl_unused;

  pni_pick #(.N(N_SRC), .LW(LVL_W)) u_pick_irq (
    .req_i(pend_irq & ~irq_mask_i), .lvl_i(irq_lvl_i),
    .vld_o(win_vld), .idx_o(win_idx), .lvl_o(win_lvl));
  pni_pick #(.N(N_SRC), .LW(LVL_W)) u_pick_ms (
    .req_i(pend_ms), .lvl_i('0),
    .vld_o(ms_vld), .idx_o(ms_idx), .lvl_o(ms_lvl_unused));

  logic             stk_push, stk_empty, stk_full;
  logic [LVL_W-1:0] stk_top;
  logic [CNT_W-1:0] stk_cnt;

  pni_stack #(.DEPTH(STK_DEPTH), .LW(LVL_W)) u_stack (
    .clk(clk), .rst_n(rst_ni), .push_i(stk_push), .lvl_i(win_lvl),
    .pop_i(eos_i), .empty_o(stk_empty), .full_o(stk_full),
    .top_o(stk_top), .cnt_o(stk_cnt));

  // next-state: arbitration
  logic             ie_q, ie_d;
  logic             ack_q, ack_d;
  ack_kind_e        kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             outranks, mask_ok;

  always_comb begin
    outranks = stk_empty || (win_lvl < stk_top) ||
               (!lock_i && (win_lvl == LVL_LAST) && (stk_top == LVL_LAST));
    mask_ok  = win_vld && ie_q && !eos_i && !stk_full && outranks;

    ack_d    = 1'b0;
    kind_d   = ACK_MASK;
    idx_d    = '0;
    clr_irq  = '0;
    clr_ms   = '0;
    clr_nmi  = 1'b0;
    stk_push = 1'b0;
    if (pend_nmi) begin
      ack_d   = 1'b1;
      kind_d  = ACK_NMI;
      clr_nmi = 1'b1;
    end else if (ms_vld) begin
      ack_d  = 1'b1;
      kind_d = ACK_MACRO;
      idx_d  = ms_idx;
      clr_ms[ms_idx] = 1'b1;
    end else if (mask_ok) begin
      ack_d    = 1'b1;
      kind_d   = ACK_MASK;
      idx_d    = win_idx;
      clr_irq[win_idx] = 1'b1;
      stk_push = 1'b1;
    end

    ie_d = ie_q;
    if (stk_push)      ie_d = 1'b0;
    else if (ie_set_i) ie_d = 1'b1;
    else if (ie_clr_i) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      ack_q  <= 1'b0;
      kind_q <= ACK_MASK;
      idx_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      ack_q  <= ack_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
    end
  end

  assign ack_o      = ack_q;
  assign ack_kind_o = kind_q;
  assign ack_idx_o  = idx_q;
  assign ie_o       = ie_q;
  assign depth_o    = stk_cnt;
  assign cur_lvl_o  = stk_top;

  // R2
  ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_q && kind_q == ACK_MASK) |-> ($past(ie_q) && !ie_q));

  // R5
  lvl0_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stk_empty && stk_top == '0) |=> !(ack_q && kind_q == ACK_MASK));

  // R8
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pend_nmi |=> (ack_q && kind_q == ACK_NMI));

  // R7
  ms_no_push_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_q && kind_q != ACK_MASK) |-> (stk_cnt == $past(stk_cnt) || $past(eos_i)));

  // R11
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_q |-> (kind_q != 2'd3));
endmodule

// File: tb/tb_prio_nest_intc.sv
`timescale 1ns/1ps
module tb_prio_nest_intc;
  localparam int N  = 8;
  localparam int LW = 2;
  localparam int SD = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq, mask, ms;
  logic [N*LW-1:0] lvl;
  logic          nmi, ie_set, ie_clr, lock, eos;
  logic          ack_o;
  logic [1:0]    ack_kind_o;
  logic [2:0]    ack_idx_o;
  logic          ie_o;
  logic [2:0]    depth_o;
  logic [1:0]    cur_lvl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int qk[$];
  int qi[$];

  always #4 clk = ~clk;

  prio_nest_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .irq_lvl_i(lvl), .irq_mask_i(mask),
    .ms_req_i(ms), .nmi_i(nmi), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
    .lock_i(lock), .eos_i(eos), .ack_o(ack_o), .ack_kind_o(ack_kind_o),
    .ack_idx_o(ack_idx_o), .ie_o(ie_o), .depth_o(depth_o), .cur_lvl_o(cur_lvl_o));

  always @(negedge clk) begin
    if (rst_n && ack_o) begin
      qk.push_back(int'(ack_kind_o));
      qi.push_back(int'(ack_idx_o));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; mask = '0; ms = '0; lvl = '0;
    nmi = 1'b0; ie_set = 1'b0; ie_clr = 1'b0; lock = 1'b0; eos = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    qk.delete(); qi.delete();
  endtask

  task automatic pulse_ie();
    ie_set = 1'b1; cyc(1); ie_set = 1'b0;
  endtask

  task automatic pulse_irq(input logic [N-1:0] v);
    irq = v; cyc(1); irq = '0;
  endtask

  task automatic pulse_eos();
    eos = 1'b1; cyc(1); eos = 1'b0;
  endtask

  task automatic set_lvl(input int i, input int l);
    lvl[i*LW +: LW] = LW'(l);
  endtask

  // expects next recorded acknowledge; kind -1 means none expected
  task automatic expect_ack(input int kind, input int idx, input string req);
    if (kind < 0) begin
      chk(qk.size() == 0, req, qk.size(), 0);
    end else if (qk.size() == 0) begin
      chk(1'b0, req, -1, idx);
    end else begin
      int k = qk.pop_front();
      int i = qi.pop_front();
      chk(k == kind && i == idx, req, k * 16 + i, kind * 16 + idx);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    chk(ack_o == 0 && ie_o == 0 && depth_o == 0, "R11", int'({ack_o, ie_o}), 0);

    // R11 timing: rise before edge k, ack after edge k+1, one-cycle strobe
    pulse_ie();
    irq = 8'h01;
    cyc(1); chk(ack_o == 0, "R11", ack_o, 0);
    irq = '0;
    cyc(1); chk(ack_o == 1 && ack_kind_o == 0 && ack_idx_o == 0, "R11", ack_o, 1);
    cyc(1); chk(ack_o == 0, "R11", ack_o, 0);
    chk(ie_o == 0, "R2", ie_o, 0);

    // R4 R5 R6 R9 nesting sweep
    for (int mode = 0; mode < 2; mode++) begin
      for (int t = 0; t < 4; t++) begin
        for (int l = 0; l < 4; l++) begin
          bit exp;
          do_reset();
          lock = mode[0];
          set_lvl(0, t); set_lvl(1, l);
          pulse_ie(); pulse_irq(8'h01); cyc(4);
          expect_ack(0, 0, "R4");
          pulse_ie(); pulse_irq(8'h02); cyc(4);
          exp = (l < t) || (l == 3 && t == 3 && mode == 0);
          if (exp) expect_ack(0, 1, t == 3 && l == 3 ? "R6" : "R4");
          else     expect_ack(-1, 0, t == 0 ? "R5" : (t == 3 && l == 3 ? "R6" : "R4"));
          pulse_eos(); cyc(4);
          if (exp) chk(depth_o == 1 && qk.size() == 0, "R9", depth_o, 1);
          else     expect_ack(0, 1, "R9");
        end
      end
    end

    // R3 ordering by level then index
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] left;
      int mul, add;
      mul = (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 0 : 2;
      add = p;
      do_reset();
      for (int i = 0; i < N; i++) set_lvl(i, (i * mul + add) % 4);
      pulse_irq('1); cyc(3);
      left = '1;
      for (int n = 0; n < N; n++) begin
        int bi, bl;
        bi = -1; bl = 99;
        for (int i = 0; i < N; i++)
          if (left[i] && ((i * mul + add) % 4) < bl) begin bi = i; bl = (i * mul + add) % 4; end
        left[bi] = 1'b0;
        pulse_ie(); cyc(4);
        expect_ack(0, bi, "R3");
        pulse_eos(); cyc(2);
      end
    end

    // R8 priority of non-maskable, then macro, then maskable
    do_reset();
    for (int i = 0; i < N; i++) set_lvl(i, 1);
    ie_set = 1'b1; irq = 8'h10; ms = 8'h40; nmi = 1'b1;
    cyc(1);
    ie_set = 1'b0; irq = '0; ms = '0; nmi = 1'b0;
    cyc(6);
    expect_ack(2, 0, "R8");
    expect_ack(1, 6, "R7");
    expect_ack(0, 4, "R8");
    chk(depth_o == 1, "R8", depth_o, 1);

    // R7 macro service under level-0 service with a pending maskable
    do_reset();
    set_lvl(0, 0); set_lvl(3, 1);
    pulse_ie(); pulse_irq(8'h01); cyc(4);
    expect_ack(0, 0, "R5");
    pulse_irq(8'h08); cyc(3);
    ms = 8'h24; cyc(1); ms = '0; cyc(5);
    expect_ack(1, 2, "R7");
    expect_ack(1, 5, "R7");
    expect_ack(-1, 0, "R7");
    chk(depth_o == 1 && cur_lvl_o == 0, "R7", depth_o, 1);
    pulse_ie(); cyc(4);
    expect_ack(-1, 0, "R5");

    // R1 mask holds pending
    do_reset();
    mask = 8'h08;
    pulse_ie(); pulse_irq(8'h08); cyc(4);
    expect_ack(-1, 0, "R1");
    mask = '0; cyc(4);
    expect_ack(0, 3, "R1");

    // R2 cleared enable blocks acknowledge
    do_reset();
    pulse_ie();
    ie_clr = 1'b1; cyc(1); ie_clr = 1'b0;
    pulse_irq(8'h04); cyc(4);
    expect_ack(-1, 0, "R2");
    pulse_ie(); cyc(4);
    expect_ack(0, 2, "R2");

    // R10 full stack
    do_reset();
    lock = 1'b0;
    for (int i = 0; i < N; i++) set_lvl(i, 3);
    for (int i = 0; i < SD + 1; i++) begin
      pulse_ie(); pulse_irq(N'(1) << i); cyc(4);
      if (i < SD) expect_ack(0, i, "R10");
      else        expect_ack(-1, 0, "R10");
    end
    chk(depth_o == SD, "R10", depth_o, SD);
    pulse_eos(); cyc(4);
    expect_ack(0, SD, "R10");
    chk(depth_o == SD, "R10", depth_o, SD);

    // R9 empty pop ignored
    do_reset();
    pulse_eos(); cyc(2);
    chk(depth_o == 0, "R9", depth_o, 0);
    pulse_ie(); pulse_irq(8'h01); cyc(4);
    expect_ack(0, 0, "R9");
    chk(depth_o == 1, "R9", depth_o, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule